// File: doc/BRIEF.md
# Key-Locked System Control Register File

This block is a bank of 32-bit control and status words spread over a 4 KB window. Each word is selected by its byte offset divided by four, and the bus presents that word index directly. A simple bus reaches the bank with separate read and write strobes that complete in one cycle. Most of the words are plain configuration storage for clocking, resets, pin setup and memory I/O tuning, and the bank gives them no further meaning. What the bank does add is protection and policing.

Configuration writes pass only while a lock is open. The lock opens when a 16-bit key is written to one slot and closes when a different key is written to another slot. Every offset belongs to one of four access classes: read-write, read-only, write-only or unmapped. An access that breaks its class, or a configuration write made while the bank is locked, is dropped where that applies and raises a one-cycle error pulse. One bit of the reset control word raises a one-cycle system reset request when a write to it is accepted.

Top module: `keylock_sysctl`

## Requirements
- R1: After reset, the lock status word (byte offset 0x00C) reads 1. The following words read their reset values: 0x0001A008 at 0x100, 0x104 and 0x108; 0x0000003F at 0x10C; 0x00014000 at 0x110, 0x114 and 0x118; 0x00000040 at 0x250; 0x00000001 at 0x25C. `access_err` and `sys_rst_req` are 0.
- R2: A write whose low 16 bits equal 0x767B at offset 0x004 sets the lock status to 1. A write of any other value there leaves the lock status unchanged and raises no error.
- R3: A write whose low 16 bits equal 0xDF0D at offset 0x008 clears the lock status to 0. A write of any other value there leaves the lock status unchanged and raises no error.
- R4: Offset 0x000 keeps only bit 0 of written data, reads back as that bit with bits 31:1 at zero, and accepts writes whether the bank is locked or not.
- R5: While the lock status is 1, a write to any offset other than 0x000, 0x004 and 0x008 leaves the stored word unchanged and raises `access_err`.
- R6: While unlocked, a write to a read-write offset stores all 32 bits, which a later read returns unchanged.
- R7: The read-only offsets are 0x00C, 0x10C, 0x17C, 0x18C, 0x19C, 0x1AC, 0x25C, 0x530, 0x618 and 0x620. A write to one of them is dropped and raises `access_err`. A read of one of them raises no error. Offset 0x530 reads the `ID_CODE` parameter, and 0x17C reads 0x00010000.
- R8: The write-only offsets are 0x004, 0x008, 0x60C and 0x614. A read of one of them raises `access_err` and still returns the stored word. The two key slots read 0. While unlocked, 0x60C and 0x614 hold their last accepted write.
- R9: An offset outside the defined map drops every write. A read of it returns 0. Both raise `access_err`.
- R10: An accepted write to offset 0x200 with bit 0 set raises `sys_rst_req` for exactly the following cycle. A write with bit 0 clear, or a write made while locked, raises no request.
- R11: `rdata` is updated in the cycle after `rd_en` and holds its value until the next read. `access_err` is high only in the single cycle after the offending access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe for the word at `word_idx` |
| wr_en | input | 1 | Write strobe for the word at `word_idx` |
| word_idx | input | 10 | Word index, equal to byte offset divided by four |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| access_err | output | 1 | One-cycle pulse after an illegal access |
| sys_rst_req | output | 1 | One-cycle pulse after an accepted soft-reset write |

## Verification
The hardest conditions to reach are the ones that need the lock open: a stored write, a write-only trigger that holds data, and the soft-reset pulse. The lock only opens after an exact key pattern lands on a slot that itself accepts no data. The stimulus therefore first sends near-miss keys, including values that differ from the key in one bit and values with noise in the upper half. Each near miss must leave the lock shut, and the bench confirms this through the lock status word before it sends the true key. Once open, the bank is relocked with the lock key and the same writes are repeated, so that each guarded path is seen both rejected and accepted.

// File: rtl/slcr_pkg.sv
package slcr_pkg;

  localparam int WIN_BYTES = 4096;
  localparam int DATA_W    = 32;
  localparam int WORDS     = WIN_BYTES / (DATA_W / 8);
  localparam int IDX_W     = $clog2(WORDS);
  localparam int KEY_W     = 16;

  localparam logic [KEY_W-1:0] KEY_CLOSE = 16'h767B;
  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'hDF0D;

  localparam logic [IDX_W-1:0] IDX_SCRATCH = IDX_W'(12'h000 >> 2);
  localparam logic [IDX_W-1:0] IDX_CLOSE   = IDX_W'(12'h004 >> 2);
  localparam logic [IDX_W-1:0] IDX_OPEN    = IDX_W'(12'h008 >> 2);
  localparam logic [IDX_W-1:0] IDX_LSTAT   = IDX_W'(12'h00C >> 2);
  localparam logic [IDX_W-1:0] IDX_SWRST   = IDX_W'(12'h200 >> 2);

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RW   = 2'd1,
    ACC_RO   = 2'd2,
    ACC_WO   = 2'd3
  } acc_e;

  // access class of one word, decided on its byte offset
  function automatic acc_e word_class(input logic [IDX_W-1:0] idx);
    logic [11:0] off;
    off = {idx, 2'b00};
    case (off) inside
      12'h004, 12'h008, 12'h60C, 12'h614:
        return ACC_WO;
      12'h00C, 12'h10C, 12'h25C, 12'h530, 12'h618, 12'h620:
        return ACC_RO;
      [12'h170:12'h1AC]:
        return (off[3:2] == 2'b11) ? ACC_RO : ACC_RW;
      12'h000, [12'h100:12'h108], [12'h110:12'h118], [12'h120:12'h16C],
      12'h1B8, 12'h1C0, 12'h1C4, [12'h200:12'h238], 12'h240, 12'h244,
      12'h24C, 12'h250, 12'h258, 12'h300, 12'h304, [12'h440:12'h448],
      12'h600, 12'h61C, [12'h700:12'h7D4], [12'h804:12'h80C],
      12'h830, 12'h834, 12'h900, 12'h910, 12'hA00, 12'hA30, 12'hA50,
      [12'hA60:12'hA8C], 12'hA90, 12'hAA0, 12'hAB0, [12'hB00:12'hB0C],
      12'hB14, 12'hB18, [12'hB40:12'hB74]:
        return ACC_RW;
      default:
        return ACC_NONE;
    endcase
  endfunction

  // power-on content of one word
  function automatic logic [DATA_W-1:0] reset_word(input logic [IDX_W-1:0] idx,
                                                   input logic [DATA_W-1:0] id_code,
                                                   input logic [DATA_W-1:0] boot_strap);
    logic [11:0] off;
    off = {idx, 2'b00};
    case (off) inside
      [12'h100:12'h108]: return 32'h0001_A008;
      12'h10C:           return 32'h0000_003F;
      [12'h110:12'h118]: return 32'h0001_4000;
      12'h120:           return 32'h1F00_0400;
      [12'h170:12'h1AC]: begin
        if (off[3:2] == 2'b00) return 32'h0010_1800;
        if (off[3:2] == 2'b11) return 32'h0001_0000;
        return '0;
      end
      12'h1B8:           return 32'h0000_001F;
      12'h1C0, 12'h1C4:  return 32'h0000_0001;
      12'h240:           return 32'h01F3_3F0F;
      12'h250:           return 32'h0000_0040;
      12'h25C:           return boot_strap;
      12'h530:           return id_code;
      [12'h708:12'h720]: return 32'h0000_0601;
      [12'h700:12'h7D4]: return 32'h0000_1601;
      12'h808, 12'h80C:  return 32'hFFFF_FFFF;
      default:           return '0;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_keylock.sv
module sysctl_keylock
  import slcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [IDX_W-1:0] idx,
  input  logic [KEY_W-1:0] key,
  output logic             lock_q
);

  logic close_hit;
  logic open_hit;

  assign close_hit = key_we && (idx == IDX_CLOSE) && (key == KEY_CLOSE);
  assign open_hit  = key_we && (idx == IDX_OPEN)  && (key == KEY_OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n)         lock_q <= 1'b1;
    else if (close_hit) lock_q <= 1'b1;
    else if (open_hit)  lock_q <= 1'b0;
  end

endmodule

// File: rtl/sysctl_access_gate.sv
module sysctl_access_gate
  import slcr_pkg::*;
(
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             wbit0,
  input  logic             lock_q,
  output logic             key_we,
  output logic             wr_commit,
  output logic             wr_bad,
  output logic             rd_bad,
  output logic             swrst_fire
);

  acc_e cls;
  logic is_key_slot;
  logic lock_exempt;

  assign cls         = word_class(idx);
  assign is_key_slot = (idx == IDX_CLOSE) || (idx == IDX_OPEN);
  assign lock_exempt = is_key_slot || (idx == IDX_SCRATCH);

  assign key_we     = wr_en && is_key_slot;
  assign wr_bad     = wr_en && ((cls == ACC_RO) || (cls == ACC_NONE) ||
                                (lock_q && !lock_exempt));
  assign wr_commit  = wr_en && !wr_bad && !is_key_slot;
  assign rd_bad     = rd_en && ((cls == ACC_WO) || (cls == ACC_NONE));
  assign swrst_fire = wr_commit && (idx == IDX_SWRST) && wbit0;

endmodule

// File: rtl/sysctl_word_bank.sv
module sysctl_word_bank
  import slcr_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_CODE    = 32'h0A5C_0001,
  parameter logic [DATA_W-1:0] BOOT_STRAP = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_commit,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lock_q,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] store_val;
  logic [DATA_W-1:0] read_val;

  assign store_val = (idx == IDX_SCRATCH) ? {{(DATA_W-1){1'b0}}, wdata[0]} : wdata;
  assign read_val  = (idx == IDX_LSTAT)   ? {{(DATA_W-1){1'b0}}, lock_q}   : mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= reset_word(IDX_W'(i), ID_CODE, BOOT_STRAP);
    end else if (wr_commit) begin
      mem[idx] <= store_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= read_val;
  end

endmodule

// File: rtl/keylock_sysctl.sv
module keylock_sysctl
  import slcr_pkg::*;
#(
  parameter logic [31:0] ID_CODE    = 32'h0A5C_0001,
  parameter logic [31:0] BOOT_STRAP = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [9:0]  word_idx,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        access_err,
  output logic        sys_rst_req
);

  logic lock_q;
  logic key_we;
  logic wr_commit;
  logic wr_bad;
  logic rd_bad;
  logic swrst_fire;

  sysctl_keylock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .key_we (key_we),
    .idx    (word_idx),
    .key    (wdata[KEY_W-1:0]),
    .lock_q (lock_q)
  );

  sysctl_access_gate u_gate (
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .idx        (word_idx),
    .wbit0      (wdata[0]),
    .lock_q     (lock_q),
    .key_we     (key_we),
    .wr_commit  (wr_commit),
    .wr_bad     (wr_bad),
    .rd_bad     (rd_bad),
    .swrst_fire (swrst_fire)
  );

  sysctl_word_bank #(
    .ID_CODE    (ID_CODE),
    .BOOT_STRAP (BOOT_STRAP)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_commit (wr_commit),
    .rd_en     (rd_en),
    .idx       (word_idx),
    .wdata     (wdata),
    .lock_q    (lock_q),
    .rdata     (rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      access_err  <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      access_err  <= wr_bad || rd_bad;
      sys_rst_req <= swrst_fire;
    end
  end

endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        wr_en,
  input logic [9:0]  word_idx,
  input logic [31:0] wdata,
  input logic        access_err,
  input logic        sys_rst_req,
  input logic        lock_q,
  input logic        wr_commit
);

  AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && word_idx == 10'd1 && wdata[15:0] == 16'h767B |=> lock_q); // R2

  AST_LOCK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && word_idx == 10'd2 && wdata[15:0] == 16'hDF0D |=> !lock_q); // R3

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (word_idx == 10'd1 || word_idx == 10'd2)) |=> $stable(lock_q)); // R2

  AST_LOCKED_WR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && lock_q && word_idx > 10'd2 |=> access_err); // R5

  AST_LOCKED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && word_idx > 10'd2 |-> !wr_commit); // R5

  AST_RO_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    word_idx == 10'h043 || word_idx == 10'h14C |-> !wr_commit); // R7

  AST_RST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(wr_commit && word_idx == 10'h080 && wdata[0])); // R10

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |-> $past(wr_en || rd_en)); // R11

endmodule

bind keylock_sysctl sysctl_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_en       (rd_en),
  .wr_en       (wr_en),
  .word_idx    (word_idx),
  .wdata       (wdata),
  .access_err  (access_err),
  .sys_rst_req (sys_rst_req),
  .lock_q      (lock_q),
  .wr_commit   (wr_commit)
);

// File: tb/test_keylock_sysctl.sv
module test_keylock_sysctl;

  localparam logic [31:0] ID_VAL = 32'h0A5C_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  word_idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        access_err;
  logic        sys_rst_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  keylock_sysctl #(.ID_CODE(ID_VAL), .BOOT_STRAP(32'h1)) i_keylock_sysctl (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .word_idx(word_idx),
    .wdata(wdata), .rdata(rdata), .access_err(access_err), .sys_rst_req(sys_rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // write at byte offset; returns the error and reset-request pulses of the next cycle
  task automatic bwr(input logic [11:0] off, input logic [31:0] d,
                     output logic err, output logic rq);
    @(negedge clk);
    wr_en = 1'b1; word_idx = off[11:2]; wdata = d;
    @(negedge clk);
    err = access_err; rq = sys_rst_req;
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic brd(input logic [11:0] off, output logic [31:0] d, output logic err);
    @(negedge clk);
    rd_en = 1'b1; word_idx = off[11:2];
    @(negedge clk);
    d = rdata; err = access_err;
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    chk("R1 err idle", {31'b0, access_err}, 32'd0);
    chk("R1 rstreq idle", {31'b0, sys_rst_req}, 32'd0);
    brd(12'h00C, d, e); chk("R1 lock status", d, 32'd1);
    brd(12'h100, d, e); chk("R1 pll ctrl0", d, 32'h0001_A008);
    brd(12'h108, d, e); chk("R1 pll ctrl2", d, 32'h0001_A008);
    brd(12'h10C, d, e); chk("R1 pll status", d, 32'h0000_003F);
    brd(12'h114, d, e); chk("R1 pll cfg", d, 32'h0001_4000);
    brd(12'h250, d, e); chk("R1 reset reason", d, 32'h0000_0040);
    brd(12'h25C, d, e); chk("R1 boot mode", d, 32'h0000_0001);
  endtask

  task automatic t_locked;
    logic [31:0] d; logic e, q;
    bwr(12'h100, 32'h1234_5678, e, q); chk("R5 locked write err", {31'b0, e}, 32'd1);
    brd(12'h100, d, e);                chk("R5 locked write dropped", d, 32'h0001_A008);
    bwr(12'h60C, 32'h0000_00FF, e, q); chk("R5 locked trigger err", {31'b0, e}, 32'd1);
    brd(12'h60C, d, e);                chk("R5 locked trigger dropped", d, 32'd0);
  endtask

  task automatic t_scratch;
    logic [31:0] d; logic e, q;
    bwr(12'h000, 32'hFFFF_FFFF, e, q); chk("R4 locked scratch no err", {31'b0, e}, 32'd0);
    brd(12'h000, d, e);                chk("R4 scratch bit0 only", d, 32'd1);
    bwr(12'h000, 32'hFFFF_FFFE, e, q);
    brd(12'h000, d, e);                chk("R4 scratch cleared", d, 32'd0);
  endtask

  task automatic t_keys;
    logic [31:0] d; logic e, q;
    bwr(12'h008, 32'h0000_1234, e, q); chk("R3 wrong key no err", {31'b0, e}, 32'd0);
    brd(12'h00C, d, e);                chk("R3 wrong key keeps lock", d, 32'd1);
    bwr(12'h008, 32'h0000_DF0C, e, q);
    brd(12'h00C, d, e);                chk("R3 near key keeps lock", d, 32'd1);
    bwr(12'h004, 32'h0000_DF0D, e, q);
    brd(12'h00C, d, e);                chk("R3 key in wrong slot", d, 32'd1);
    bwr(12'h008, 32'hABCD_DF0D, e, q); chk("R3 open no err", {31'b0, e}, 32'd0);
    brd(12'h00C, d, e);                chk("R3 opened", d, 32'd0);
    bwr(12'h004, 32'h0000_767A, e, q);
    brd(12'h00C, d, e);                chk("R2 near key stays open", d, 32'd0);
    bwr(12'h004, 32'hFFFF_767B, e, q); chk("R2 close no err", {31'b0, e}, 32'd0);
    brd(12'h00C, d, e);                chk("R2 closed", d, 32'd1);
    bwr(12'h008, 32'h0000_DF0D, e, q);
    brd(12'h00C, d, e);                chk("R3 reopened", d, 32'd0);
  endtask

  task automatic t_rw;
    logic [31:0] d; logic e, q;
    bwr(12'h100, 32'hDEAD_BEEF, e, q); chk("R6 rw no err", {31'b0, e}, 32'd0);
    brd(12'h100, d, e);                chk("R6 rw readback", d, 32'hDEAD_BEEF);
    bwr(12'hB74, 32'h5A5A_A5A5, e, q);
    brd(12'hB74, d, e);                chk("R6 last word readback", d, 32'h5A5A_A5A5);
    bwr(12'h7D4, 32'h0000_1234, e, q);
    brd(12'h7D4, d, e);                chk("R6 pin word readback", d, 32'h0000_1234);
  endtask

  task automatic t_ro;
    logic [31:0] d; logic e, q;
    bwr(12'h10C, 32'h0, e, q); chk("R7 ro write err", {31'b0, e}, 32'd1);
    brd(12'h10C, d, e);        chk("R7 ro kept", d, 32'h3F);
    chk("R7 ro read no err", {31'b0, e}, 32'd0);
    bwr(12'h530, 32'h0, e, q); chk("R7 id write err", {31'b0, e}, 32'd1);
    brd(12'h530, d, e);        chk("R7 id value", d, ID_VAL);
    bwr(12'h17C, 32'h0, e, q); chk("R7 thr sta write err", {31'b0, e}, 32'd1);
    brd(12'h17C, d, e);        chk("R7 thr sta kept", d, 32'h0001_0000);
    bwr(12'h00C, 32'h1, e, q); chk("R7 lock status write err", {31'b0, e}, 32'd1);
    brd(12'h00C, d, e);        chk("R7 lock status unchanged", d, 32'd0);
  endtask

  task automatic t_wo;
    logic [31:0] d; logic e, q;
    bwr(12'h60C, 32'hCAFE_0001, e, q); chk("R8 wo write no err", {31'b0, e}, 32'd0);
    brd(12'h60C, d, e);                chk("R8 wo read err", {31'b0, e}, 32'd1);
    chk("R8 wo stored word", d, 32'hCAFE_0001);
    brd(12'h004, d, e);                chk("R8 key slot read err", {31'b0, e}, 32'd1);
    chk("R8 key slot reads zero", d, 32'd0);
  endtask

  task automatic t_invalid;
    logic [31:0] d; logic e, q;
    bwr(12'h010, 32'hFFFF_FFFF, e, q); chk("R9 invalid write err", {31'b0, e}, 32'd1);
    brd(12'h010, d, e);                chk("R9 invalid read err", {31'b0, e}, 32'd1);
    chk("R9 invalid reads zero", d, 32'd0);
    bwr(12'hFFC, 32'h1234_5678, e, q);
    brd(12'hFFC, d, e);                chk("R9 top invalid zero", d, 32'd0);
  endtask

  task automatic t_softrst;
    logic [31:0] d; logic e, q;
    bwr(12'h200, 32'h0000_0002, e, q); chk("R10 bit0 clear no req", {31'b0, q}, 32'd0);
    bwr(12'h200, 32'h0000_0001, e, q); chk("R10 req raised", {31'b0, q}, 32'd1);
    @(negedge clk);                    chk("R10 req one cycle", {31'b0, sys_rst_req}, 32'd0);
    bwr(12'h004, 32'h0000_767B, e, q);
    bwr(12'h200, 32'h0000_0001, e, q); chk("R10 locked no req", {31'b0, q}, 32'd0);
    chk("R10 locked write err", {31'b0, e}, 32'd1);
  endtask

  task automatic t_timing;
    logic [31:0] d; logic e, q;
    brd(12'h100, d, e);
    repeat (3) @(negedge clk);
    chk("R11 rdata holds", rdata, d);
    bwr(12'h010, 32'h0, e, q);
    chk("R11 err pulse", {31'b0, e}, 32'd1);
    @(negedge clk);
    chk("R11 err one cycle", {31'b0, access_err}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_scratch();
    t_keys();
    t_rw();
    t_ro();
    t_wo();
    t_invalid();
    t_softrst();
    t_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule